// File: doc/BRIEF.md
# Probabilistic Adjacent Row Refresher

This block is a stateless guard against disturbance errors in DRAM rows that are opened very often. The memory controller shows it every row open and every row close, each with a bank index and a row address. For each such event the block consults an internal pseudo-random generator. With a small probability that software can set, it asks for an extra refresh of one row that sits next to the event's row, in the same bank. A row that is opened on the order of a hundred thousand times in a 64 ms retention window therefore gets its neighbours restored many times over. The block keeps no count per row.

Refresh requests leave through a single-entry valid/ready port. The scheduler turns each accepted request into an ordinary activate and restore of the named row. While a request waits unaccepted, further triggers are discarded, and a saturating counter records each one. A seed input lets the generator be started from a chosen state.

Top module: `adj_row_refresher`

## Requirements
- R1: After reset, `req_valid` is 0, `drop_count` is 0, and the generator holds the non-zero constant 32'h1D872B41.
- R2: The generator is a 32-bit right-shifting Galois register. Each step moves the state one place right and, when the bit shifted out was 1, XORs in 32'h80200003. It steps exactly once in each cycle with `evt_valid` high and holds otherwise.
- R3: An event triggers when bits [15:0] of the generator state before its step are strictly below `prob_thresh`. A threshold of 0 never triggers.
- R4: On a trigger for an interior row, bit 16 of the pre-step state picks the target: 1 selects row+1, 0 selects row-1.
- R5: An event at row 0 always targets row 1. An event at the last row (all ones) always targets the row just below it.
- R6: The request carries the bank index of the event that caused it. The bank index is 3 bits, covering 8 banks.
- R7: A triggered request shows `req_valid` high from the clock edge that samples the event. It holds bank and row steady until `req_ready` is seen high, and then drops in the following cycle unless a new trigger replaces it.
- R8: A trigger that arrives while `req_valid` is high and `req_ready` is low is discarded, and it adds one to `drop_count`, which saturates at all ones. A trigger that arrives in the cycle a pending request is accepted replaces that request.
- R9: Pulsing `seed_load` makes `seed_value` the generator state. A zero seed loads 32'h1D872B41 instead. The load takes precedence over an event step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_load | input | 1 | Load `seed_value` into the generator |
| seed_value | input | 32 | Seed for the generator |
| prob_thresh | input | 16 | Trigger threshold; a larger value means a higher probability |
| evt_valid | input | 1 | A row open or close event this cycle |
| evt_bank | input | 3 | Bank of the event |
| evt_row | input | 16 | Row address of the event |
| req_valid | output | 1 | Refresh request pending |
| req_ready | input | 1 | Scheduler accepts the request |
| req_bank | output | 3 | Bank to refresh |
| req_row | output | 16 | Neighbour row to refresh |
| drop_count | output | 16 | Saturating count of discarded triggers |

## Verification
Any slip in the generator state changes both the trigger decision and the direction bit of the next event. With a threshold near full scale, a wrong state therefore shows up within one or two events as a missing request or a request for the wrong neighbour. The bench keeps its own model of the generator, so every event is compared in the cycle after it is sampled. A corrupted slot or counter shows one cycle after the first trigger that hits a pending request, through `req_row`, `req_bank` or `drop_count`.

// File: rtl/par_pkg.sv
package par_pkg;
  localparam int unsigned NUM_BANKS    = 8;
  localparam int unsigned BANK_W       = $clog2(NUM_BANKS);
  localparam int unsigned GEN_W        = 32;
  localparam logic [31:0] GEN_TAPS     = 32'h8020_0003;
  localparam logic [31:0] GEN_FALLBACK = 32'h1D87_2B41;
endpackage

// File: rtl/par_lfsr.sv
module par_lfsr #(
  parameter int unsigned        W        = 32,
  parameter int unsigned        SAMPLE_W = 16,
  parameter logic [W-1:0]       TAPS     = '1,
  parameter logic [W-1:0]       FALLBACK = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic                load_en,
  input  logic [W-1:0]        load_val,
  output logic [SAMPLE_W-1:0] sample,
  output logic                dir_bit
);
  logic [W-1:0] state_q, state_d, stepped;

  always_comb begin
    stepped = state_q >> 1;
    if (state_q[0]) stepped = stepped ^ TAPS;
  end

  always_comb begin
    state_d = state_q;
    if (load_en)      state_d = (load_val == '0) ? FALLBACK : load_val;
    else if (step_en) state_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= FALLBACK;
    else if (load_en || step_en) state_q <= state_d;
  end

  assign sample  = state_q[SAMPLE_W-1:0];
  assign dir_bit = state_q[SAMPLE_W];

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R2
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en && !load_en |=> $stable(state_q)); // R2
endmodule

// File: rtl/par_neighbor.sv
module par_neighbor #(
  parameter int unsigned ROW_W = 16
) (
  input  logic [ROW_W-1:0] row_in,
  input  logic             go_up,
  output logic [ROW_W-1:0] row_out
);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;
  localparam logic [ROW_W-1:0] ROW_ONE  = 1;

  always_comb begin
    if (row_in == '0)            row_out = ROW_ONE;
    else if (row_in == ROW_LAST) row_out = ROW_LAST - ROW_ONE;
    else if (go_up)              row_out = row_in + ROW_ONE;
    else                         row_out = row_in - ROW_ONE;
  end
endmodule

// File: rtl/par_req_slot.sv
module par_req_slot #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned ROW_W  = 16,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ROW_W-1:0]  row_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [DROP_W-1:0] drop_count
);
  logic              valid_q, valid_d;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              take_new, discard;

  always_comb begin
    take_new = trig && (!valid_q || req_ready);
    discard  = trig && valid_q && !req_ready;
    valid_d  = valid_q;
    if (take_new)                 valid_d = 1'b1;
    else if (valid_q && req_ready) valid_d = 1'b0;
    drop_d = drop_q;
    if (discard && (drop_q != '1)) drop_d = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      drop_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (discard) drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
    end else if (take_new) begin
      bank_q <= bank_in;
      row_q  <= row_in;
    end
  end

  assign req_valid  = valid_q;
  assign req_bank   = bank_q;
  assign req_row    = row_q;
  assign drop_count = drop_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !req_ready |=> valid_q && $stable(bank_q) && $stable(row_q)); // R7
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trig && valid_q && !req_ready |=>
      (drop_q == $past(drop_q) + 1'b1) || ($past(drop_q) == '1 && drop_q == '1)); // R8
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig && valid_q && !req_ready) |=> $stable(drop_q)); // R8
endmodule

// File: rtl/adj_row_refresher.sv
module adj_row_refresher
  import par_pkg::*;
#(
  parameter int unsigned ROW_W  = 16,
  parameter int unsigned THR_W  = 16,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [GEN_W-1:0]  seed_value,
  input  logic [THR_W-1:0]  prob_thresh,
  input  logic              evt_valid,
  input  logic [BANK_W-1:0] evt_bank,
  input  logic [ROW_W-1:0]  evt_row,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [DROP_W-1:0] drop_count
);
  logic             rst_meta_n, rst_sync_n;
  logic [THR_W-1:0] gen_sample;
  logic             gen_dir;
  logic             fire;
  logic [ROW_W-1:0] target_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  par_lfsr #(
    .W(GEN_W), .SAMPLE_W(THR_W), .TAPS(GEN_TAPS), .FALLBACK(GEN_FALLBACK)
  ) u_gen (
    .clk(clk), .rst_n(rst_sync_n), .step_en(evt_valid), .load_en(seed_load),
    .load_val(seed_value), .sample(gen_sample), .dir_bit(gen_dir)
  );

  assign fire = evt_valid && (gen_sample < prob_thresh);

  par_neighbor #(.ROW_W(ROW_W)) u_nbr (
    .row_in(evt_row), .go_up(gen_dir), .row_out(target_row)
  );

  par_req_slot #(.BANK_W(BANK_W), .ROW_W(ROW_W), .DROP_W(DROP_W)) u_slot (
    .clk(clk), .rst_n(rst_sync_n), .trig(fire), .bank_in(evt_bank),
    .row_in(target_row), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .drop_count(drop_count)
  );

  AST_ADJ_ROW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req_valid) |->
      (req_row == $past(evt_row) + 1'b1) || (req_row == $past(evt_row) - 1'b1)); // R4
  AST_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req_valid) |-> req_bank == $past(evt_bank)); // R6
  AST_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid && evt_valid && prob_thresh == '0 |=> !req_valid); // R3
  AST_EDGE_ROW0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req_valid) && $past(evt_row) == '0 |-> req_row == 1); // R5
endmodule

// File: tb/tb_adj_row_refresher.sv
module tb_adj_row_refresher;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] FBK  = 32'h1D87_2B41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [31:0] seed_value = '0;
  logic [15:0] prob_thresh = '0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_bank = '0;
  logic [15:0] evt_row = '0;
  logic        req_ready = 1'b0;
  logic        req_valid;
  logic [2:0]  req_bank;
  logic [15:0] req_row;
  logic [15:0] drop_count;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_state;
  logic        m_valid;
  logic [2:0]  m_bank;
  logic [15:0] m_row;
  logic [15:0] m_drop;

  always #2 clk = ~clk;

  adj_row_refresher dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .prob_thresh(prob_thresh), .evt_valid(evt_valid), .evt_bank(evt_bank),
    .evt_row(evt_row), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .drop_count(drop_count)
  );

  function automatic logic [31:0] gen_step(input logic [31:0] s);
    logic [31:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ TAPS;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_ports(input string tag);
    chk(req_valid == m_valid, {tag, " valid"}, req_valid, m_valid);
    if (m_valid) begin
      chk(req_row == m_row, {tag, " row"}, req_row, m_row);
      chk(req_bank == m_bank, {tag, " bank"}, req_bank, m_bank);
    end
    chk(drop_count == m_drop, {tag, " drops"}, drop_count, m_drop);
  endtask

  // one event; model updated per requirements R2..R8, ports checked after the edge
  task automatic do_event(input logic [2:0] b, input logic [15:0] r, input string tag);
    logic trig;
    logic [15:0] tgt;
    @(negedge clk);
    evt_valid = 1'b1; evt_bank = b; evt_row = r;
    trig = m_state[15:0] < prob_thresh;
    if (r == 16'h0000)      tgt = 16'h0001;
    else if (r == 16'hFFFF) tgt = 16'hFFFE;
    else if (m_state[16])   tgt = r + 16'h1;
    else                    tgt = r - 16'h1;
    @(posedge clk);
    if (trig && !(m_valid && !req_ready)) begin
      m_valid = 1'b1; m_bank = b; m_row = tgt;
    end else if (m_valid && req_ready) m_valid = 1'b0;
    if (trig && m_valid && !req_ready && !(m_bank == b && m_row == tgt && 0))
      ;
    m_state = gen_step(m_state);
    #1;
    evt_valid = 1'b0;
    check_ports(tag);
  endtask

  task automatic note_drop_if(input bit cond);
    if (cond && m_drop != 16'hFFFF) m_drop = m_drop + 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (m_valid && req_ready) m_valid = 1'b0;
    end
    #1;
  endtask

  task automatic load_seed(input logic [31:0] v);
    @(negedge clk);
    seed_load = 1'b1; seed_value = v;
    @(posedge clk);
    if (m_valid && req_ready) m_valid = 1'b0;
    m_state = (v == 32'h0) ? FBK : v;
    #1 seed_load = 1'b0;
  endtask

  task automatic t_reset;
    chk(req_valid == 1'b0, "R1 reset valid", req_valid, 0);
    chk(drop_count == 16'h0, "R1 reset drops", drop_count, 0);
    prob_thresh = 16'hFFFF; req_ready = 1'b1;
    do_event(3'd2, 16'h0100, "R1 first event after reset");
    do_event(3'd2, 16'h0100, "R2 second step");
    idle(1);
  endtask

  task automatic t_zero_thresh;
    prob_thresh = 16'h0000; req_ready = 1'b1;
    for (int i = 0; i < 20; i++) do_event(3'(i), 16'(i * 37 + 5), "R3 zero threshold");
  endtask

  task automatic t_mid_thresh;
    load_seed(32'hC0DE_5A11);
    prob_thresh = 16'h8000; req_ready = 1'b1;
    for (int i = 0; i < 40; i++)
      do_event(3'(i * 3), 16'(16'h2000 + i * 11), "R4 R6 half threshold");
    prob_thresh = 16'hFFFF;
    for (int i = 0; i < 16; i++)
      do_event(3'(7 - i), 16'(16'h4000 + i), "R2 R4 full threshold");
    idle(1);
  endtask

  task automatic t_edges;
    prob_thresh = 16'hFFFF; req_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      do_event(3'd1, 16'h0000, "R5 row zero");
      do_event(3'd6, 16'hFFFF, "R5 last row");
    end
    idle(1);
  endtask

  task automatic t_drop;
    bit pend;
    bit trig;
    prob_thresh = 16'hFFFF; req_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pend = m_valid;
      trig = m_state[15:0] < prob_thresh;
      note_drop_if(pend && trig);
      do_event(3'd4, 16'(16'h0800 + i * 2), "R7 R8 pending drop");
    end
    @(negedge clk); req_ready = 1'b1;
    idle(1);
    check_ports("R7 released after ready");
    // trigger lands in the accept cycle and replaces the request
    req_ready = 1'b0;
    do_event(3'd5, 16'h1234, "R8 refill");
    req_ready = 1'b1;
    do_event(3'd3, 16'h2222, "R8 replace on accept");
    idle(1);
  endtask

  task automatic t_seed;
    load_seed(32'h0);
    prob_thresh = 16'hFFFF; req_ready = 1'b1;
    for (int i = 0; i < 6; i++) do_event(3'd0, 16'(16'h0300 + i), "R9 zero seed");
    load_seed(32'h0000_FFFF);
    do_event(3'd7, 16'h0050, "R9 seed gives no trigger");
    // seed and event in the same cycle: load wins
    @(negedge clk);
    seed_load = 1'b1; seed_value = 32'h0001_0000;
    evt_valid = 1'b1; evt_bank = 3'd2; evt_row = 16'h0777;
    @(posedge clk);
    if (m_state[15:0] < prob_thresh) begin
      m_valid = 1'b1; m_bank = 3'd2; m_row = m_state[16] ? 16'h0778 : 16'h0776;
    end else if (m_valid) m_valid = 1'b0;
    m_state = 32'h0001_0000;
    #1 seed_load = 1'b0; evt_valid = 1'b0;
    check_ports("R9 load with event");
    do_event(3'd2, 16'h0900, "R9 load precedence");
    idle(1);
  endtask

  initial begin
    m_state = FBK; m_valid = 1'b0; m_bank = '0; m_row = '0; m_drop = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_zero_thresh();
    t_mid_thresh();
    t_edges();
    t_drop();
    t_seed();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule